// File: doc/BRIEF.md
# Eight-Channel Transmit Queue Arbiter

This block decides which of eight transmit queues the transmit engine serves next. Each queue raises its request line while it holds at least one packet. When the arbiter is free and a request is present, it registers a winner and presents it as a one-hot grant vector together with its binary index. The grant stays in place for the whole packet. It is released only when the downstream engine signals that the packet has finished.

A single mode input chooses how the winner is picked. In fixed-priority mode the highest-numbered requesting channel wins. In rotating mode the search starts just above the channel served last, climbs toward channel 7 and wraps to channel 0.

A pause hold-off prevents new grants while a pause timer is running. The hold-off applies only when the link is full duplex and transmit flow control is enabled. A packet already in progress is never cut short by a pause.

The controller has three named states:
- `ST_IDLE`: searching for a winner.
- `ST_BUSY`: a grant is held.
- `ST_HOLD`: paused, no new grant.

Its transitions are:
- `ST_IDLE`→`ST_HOLD` when the pause hold-off is active.
- `ST_IDLE`→`ST_BUSY` when any request is present and no hold-off is active.
- `ST_HOLD`→`ST_IDLE` when the hold-off ends.
- `ST_BUSY`→`ST_IDLE` on the packet-done handshake.

Top module: `tq_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gnt` is all zeros and `gnt_valid` is 0.
- R2: `gnt` never has more than one bit set. Whenever `gnt_valid` is 1, bit number `gnt_idx` of `gnt` is the bit that is set.
- R3: With `rr_mode`=0 (fixed), the channel granted is the highest-numbered channel whose request bit was set in the cycle the decision was made.
- R4: With `rr_mode`=1 (rotating), the search begins at the channel one above the last channel served in either mode, ascends and wraps from 7 to 0. After reset the first rotating search begins at channel 0.
- R5: A grant appears in the cycle after the arbiter in `ST_IDLE` sees a request. It stays unchanged, even if requests change, until `pkt_done` is sampled high. It is cleared in the cycle after that.
- R6: While `pause_active`, `full_duplex` and `tx_flow_en` are all 1, no new grant is issued. A grant follows two cycles after `pause_active` falls if requests are present.
- R7: When `full_duplex`=0 or `tx_flow_en`=0, `pause_active` has no effect on granting.
- R8: A pause that becomes active during a granted packet leaves that grant in place until `pkt_done`. Only the following grant is held back.
- R9: With no request bit set, `gnt_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | Per-channel queue-not-empty requests |
| rr_mode | input | 1 | 0 = fixed priority, 1 = rotating |
| full_duplex | input | 1 | Link operates in full duplex |
| tx_flow_en | input | 1 | Transmit flow control enabled |
| pause_active | input | 1 | Pause timer is non-zero |
| pkt_done | input | 1 | Current packet has finished |
| gnt | output | 8 | One-hot grant |
| gnt_idx | output | 3 | Index of the granted channel |
| gnt_valid | output | 1 | A grant is held |

## Verification
The following properties are checked on every cycle:
- The grant is one-hot and agrees with `gnt_idx`.
- A new grant goes only to a channel that was requesting.
- In fixed mode no higher-numbered channel was requesting at the moment of the grant.
- The grant stays stable until `pkt_done` and drops after it.
- A qualified pause never lets a new grant start.

Only the bench's scenarios can show the following:
- The rotating order, including the wrap and the start at channel 0 after reset.
- That a pause is ignored when either qualifier is off.
- That a grant follows once the pause ends.

// File: rtl/tq_arb_pkg.sv
package tq_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } arb_state_t;
endpackage

// File: rtl/tq_pause_gate.sv
module tq_pause_gate (
    input  logic pause_active,
    input  logic full_duplex,
    input  logic tx_flow_en,
    output logic hold_off
);
    // Pause only counts on a full-duplex link with flow control on (R6, R7)
    assign hold_off = pause_active & full_duplex & tx_flow_en;
endmodule

// File: rtl/tq_fixed_pick.sv
module tq_fixed_pick #(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic [IW-1:0]  sel
);
    // Ascending scan; the last hit, the highest index, wins (R3)
    always_comb begin
        sel = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i]) sel = IW'(i);
        end
    end
endmodule

// File: rtl/tq_rr_pick.sv
module tq_rr_pick #(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    input  logic [IW-1:0]  last,
    output logic [IW-1:0]  sel
);
    // Search starts one above the last served channel and wraps (R4)
    always_comb begin
        logic found;
        int   start;
        int   j;
        found = 1'b0;
        sel   = '0;
        start = (int'(last) + 1) % NCH;
        for (int k = 0; k < NCH; k++) begin
            j = (start + k) % NCH;
            if (!found && req[j]) begin
                found = 1'b1;
                sel   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/tq_arb.sv
module tq_arb
    import tq_arb_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic           rr_mode,
    input  logic           full_duplex,
    input  logic           tx_flow_en,
    input  logic           pause_active,
    input  logic           pkt_done,
    output logic [NCH-1:0] gnt,
    output logic [IW-1:0]  gnt_idx,
    output logic           gnt_valid
);
    arb_state_t state_q, state_d;
    logic          hold_off;
    logic          any_req;
    logic [IW-1:0] fx_sel, rr_sel, pick;
    logic [IW-1:0] cur_q, last_q;

    tq_pause_gate u_gate (
        .pause_active (pause_active),
        .full_duplex  (full_duplex),
        .tx_flow_en   (tx_flow_en),
        .hold_off     (hold_off)
    );

    tq_fixed_pick #(.NCH(NCH)) u_fix (
        .req (req),
        .sel (fx_sel)
    );

    tq_rr_pick #(.NCH(NCH)) u_rr (
        .req  (req),
        .last (last_q),
        .sel  (rr_sel)
    );

    assign any_req = |req;
    assign pick    = rr_mode ? rr_sel : fx_sel;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_off)     state_d = ST_HOLD;
                else if (any_req) state_d = ST_BUSY;
            end
            ST_HOLD: begin
                if (!hold_off)    state_d = ST_IDLE;
            end
            ST_BUSY: begin
                if (pkt_done)     state_d = ST_IDLE;
            end
            default:              state_d = ST_IDLE;
        endcase
    end

    // Winner capture and last-served tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            last_q <= IW'(NCH - 1);
        end else begin
            if (state_q == ST_IDLE && !hold_off && any_req) cur_q <= pick;
            if (state_q == ST_BUSY && pkt_done)             last_q <= cur_q;
        end
    end

    // Outputs from registered state
    always_comb begin
        gnt_valid = (state_q == ST_BUSY);
        gnt_idx   = cur_q;
        gnt       = '0;
        if (gnt_valid) gnt[cur_q] = 1'b1;
    end
endmodule

// File: rtl/tq_arb_chk.sv
module tq_arb_chk #(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] req,
    input logic           rr_mode,
    input logic           full_duplex,
    input logic           tx_flow_en,
    input logic           pause_active,
    input logic           pkt_done,
    input logic [NCH-1:0] gnt,
    input logic [IW-1:0]  gnt_idx,
    input logic           gnt_valid
);
    logic [NCH-1:0] req_q;
    logic           mode_q;
    logic           blk;

    assign blk = pause_active & full_duplex & tx_flow_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            req_q  <= req;
            mode_q <= rr_mode;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (gnt == '0 && !gnt_valid));

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_idx_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (gnt == (NCH'(1) << gnt_idx)));

    assert_grant_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> req_q[gnt_idx]);

    assert_fixed_highest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gnt_valid) && !mode_q) |-> (((req_q >> gnt_idx) >> 1) == '0));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !pkt_done) |=> (gnt_valid && $stable(gnt_idx)));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && pkt_done) |=> !gnt_valid);

    assert_pause_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && !gnt_valid) |=> !gnt_valid);
endmodule

bind tq_arb tq_arb_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_tq_arb.sv
module tb_tq_arb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req;
    logic       rr_mode, full_duplex, tx_flow_en, pause_active, pkt_done;
    logic [7:0] gnt;
    logic [2:0] gnt_idx;
    logic       gnt_valid;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tq_arb dut (
        .clk(clk), .rst_n(rst_n), .req(req), .rr_mode(rr_mode),
        .full_duplex(full_duplex), .tx_flow_en(tx_flow_en),
        .pause_active(pause_active), .pkt_done(pkt_done),
        .gnt(gnt), .gnt_idx(gnt_idx), .gnt_valid(gnt_valid)
    );

    // {mode, req, expected index}; rotating rows depend on the row before
    localparam logic [11:0] VEC [15] = '{
        {1'b1, 8'hFF, 3'd0},  // R4 first rotating search after reset
        {1'b0, 8'h05, 3'd2},  // R3
        {1'b0, 8'h81, 3'd7},  // R3
        {1'b0, 8'h50, 3'd6},  // R3
        {1'b0, 8'h01, 3'd0},  // R3
        {1'b1, 8'h83, 3'd1},  // R4
        {1'b1, 8'h83, 3'd7},  // R4
        {1'b1, 8'h83, 3'd0},  // R4 wrap
        {1'b1, 8'h01, 3'd0},  // R4 only requester again
        {1'b1, 8'hFF, 3'd1},  // R4
        {1'b1, 8'hFF, 3'd2},  // R4
        {1'b1, 8'h14, 3'd4},  // R4
        {1'b0, 8'h3F, 3'd5},  // R3
        {1'b1, 8'h21, 3'd0},  // R4 wrap past 6,7
        {1'b1, 8'h21, 3'd5}   // R4
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_pkt(string tag);
        pkt_done = 1'b1;
        tick();
        pkt_done = 1'b0;
        check(tag, {31'd0, gnt_valid}, 32'd0);
    endtask

    initial begin
        #(5ns * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = '0; rr_mode = 1'b0; full_duplex = 1'b0;
        tx_flow_en = 1'b0; pause_active = 1'b0; pkt_done = 1'b0;
        tick();
        check("R1 gnt in reset", {24'd0, gnt}, 32'd0);
        tick();
        rst_n = 1'b1;
        tick();
        check("R1 gnt after reset", {24'd0, gnt}, 32'd0);
        check("R1 valid after reset", {31'd0, gnt_valid}, 32'd0);

        // Vector table walk
        for (int v = 0; v < 15; v++) begin
            rr_mode = VEC[v][11];
            req     = VEC[v][10:3];
            tick();
            check(VEC[v][11] ? "R4 rotating idx" : "R3 fixed idx",
                  {29'd0, gnt_idx}, {29'd0, VEC[v][2:0]});
            check("R2 one-hot", {24'd0, gnt}, 32'(8'd1 << VEC[v][2:0]));
            req = '0;
            finish_pkt("R5 release");
        end

        // R9: no requests, no grant
        rr_mode = 1'b0; req = '0;
        for (int c = 0; c < 3; c++) begin
            tick();
            check("R9 no request", {31'd0, gnt_valid}, 32'd0);
        end

        // R5: grant held while requests change
        req = 8'h08;
        tick();
        check("R5 grant idx", {29'd0, gnt_idx}, 32'd3);
        req = 8'h80;
        for (int c = 0; c < 3; c++) begin
            tick();
            check("R5 held idx", {29'd0, gnt_idx}, 32'd3);
        end
        finish_pkt("R5 release after hold");
        tick();
        check("R5 next grant", {29'd0, gnt_idx}, 32'd7);
        req = '0;
        finish_pkt("R5 release");

        // R6: qualified pause blocks new grants
        full_duplex = 1'b1; tx_flow_en = 1'b1; pause_active = 1'b1;
        tick();
        req = 8'hFF;
        for (int c = 0; c < 4; c++) begin
            tick();
            check("R6 paused", {31'd0, gnt_valid}, 32'd0);
        end
        pause_active = 1'b0;
        tick();
        check("R6 one cycle after pause", {31'd0, gnt_valid}, 32'd0);
        tick();
        check("R6 grant after pause", {31'd0, gnt_valid}, 32'd1);
        check("R6 idx", {29'd0, gnt_idx}, 32'd7);
        req = '0;
        finish_pkt("R6 release");

        // R7: pause ignored in half duplex
        full_duplex = 1'b0; tx_flow_en = 1'b1; pause_active = 1'b1;
        req = 8'h02;
        tick();
        check("R7 half duplex grant", {31'd0, gnt_valid}, 32'd1);
        req = '0;
        finish_pkt("R7 release");
        // R7: pause ignored with flow control off
        full_duplex = 1'b1; tx_flow_en = 1'b0;
        req = 8'h10;
        tick();
        check("R7 flow off grant", {29'd0, gnt_idx}, 32'd4);
        check("R7 flow off valid", {31'd0, gnt_valid}, 32'd1);
        req = '0;
        finish_pkt("R7 release");

        // R8: pause mid-packet does not abort
        pause_active = 1'b0; tx_flow_en = 1'b1; full_duplex = 1'b1;
        req = 8'h40;
        tick();
        check("R8 grant", {29'd0, gnt_idx}, 32'd6);
        pause_active = 1'b1;
        for (int c = 0; c < 3; c++) begin
            tick();
            check("R8 kept", {31'd0, gnt_valid}, 32'd1);
        end
        finish_pkt("R8 release");
        for (int c = 0; c < 3; c++) begin
            tick();
            check("R8 next held back", {31'd0, gnt_valid}, 32'd0);
        end
        pause_active = 1'b0;
        tick();
        tick();
        check("R8 grant resumes", {31'd0, gnt_valid}, 32'd1);
        req = '0;
        finish_pkt("R8 final release");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule